// File: doc/BRIEF.md
# Deferred-Write Depth Test Unit

This block decides, fragment by fragment, whether a fragment survives the depth and alpha tests of a rasteriser. The fragment's depth is first compared against a small on-chip depth buffer on entry. A fragment that is hidden is marked rejected at once and never issues a texel fetch. A fragment that is visible issues a fetch to a texture model. That model returns the fragment's 8-bit alpha after a fixed number of cycles.

A fragment whose alpha is zero is discarded and leaves the buffer untouched. The buffer is written only after the alpha test has passed. Between the first test and the write, a fragment ahead of it at the same pixel may already have stored a nearer depth. For that reason the compare is repeated against the live buffer in the same cycle as the write. Any fragment that loses this second compare is rejected without writing.

Fragments enter over a valid/ready stream. Every fragment, kept or rejected, leaves in order on an output valid/ready stream carrying its coordinates, its depth and a two-bit result code. When the output holds a result that is not accepted, the whole pipeline freezes and input ready drops; nothing is lost or reordered. Three free-running counters tally the rejects of each kind.

Top module: `zdefer_unit`

## Requirements
- R1: After reset, out_valid is 0 and all three counters are 0. in_ready then stays low for exactly 2^(XW+YW) cycles (1024 by default) while every depth entry is set to all ones.
- R2: A fragment whose depth is not strictly less than the stored depth at its pixel (address {y,x}) fails the early test. Its result code is 1 and it issues no texel fetch.
- R3: tex_req is high in a cycle only when a fragment is accepted (in_valid and in_ready) in that cycle and passes the early test.
- R4: A fragment that passes the early test and whose returned alpha is 0 gets result code 2 and leaves the depth buffer unchanged.
- R5: A fragment that passes the early test, has non-zero alpha and is still strictly nearer than the stored depth at write time gets result code 0. Its depth becomes the new stored value at its pixel.
- R6: A fragment that passed the early test but is no longer strictly nearer at write time, because an older fragment at the same pixel wrote first, gets result code 3 and does not write.
- R7: Results leave in acceptance order, echoing x, y and depth. Each appears exactly TEX_LAT cycles after acceptance, plus one cycle for each stalled cycle in between.
- R8: While out_valid is high and out_ready is low, in_ready is low and the output fields hold their values into the next cycle.
- R9: Each result with code 1, 2 or 3 adds one to cnt_early, cnt_alpha or cnt_late respectively, in the cycle the result appears.
- R10: A fragment accepted in the same cycle as a depth write to its pixel is early-tested against the value being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fragment offered |
| in_ready | output | 1 | Fragment can be taken this cycle |
| in_x | input | XW | Fragment column |
| in_y | input | YW | Fragment row |
| in_z | input | ZW | Fragment depth, smaller is nearer |
| in_alpha | input | AW | Alpha the texture model returns for this fragment |
| tex_req | output | 1 | Texel fetch issued for the fragment accepted this cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle |
| out_x | output | XW | Column of the result |
| out_y | output | YW | Row of the result |
| out_z | output | ZW | Depth of the result |
| out_code | output | 2 | 0 kept, 1 early reject, 2 alpha reject, 3 late reject |
| cnt_early | output | CW | Early-reject count |
| cnt_alpha | output | CW | Alpha-reject count |
| cnt_late | output | CW | Late-reject count |
| init_busy | output | 1 | Depth buffer clear in progress |

## Verification
The bench builds the unit with its default parameters: a 32x32 buffer, 16-bit depth, 8-bit alpha and a four-cycle texture delay. With a four-cycle delay, four fragments can be in flight at once. Random traffic is confined to a 4x4 corner of the screen with a narrow depth range, so same-pixel fragments routinely overlap in the pipeline. This drives the late test to reject after an early pass, and makes random stalls land while writes are pending. The write-forwarding case is placed by timing a second fragment to arrive exactly on the first one's write cycle.

// File: rtl/zdu_pkg.sv
package zdu_pkg;

  typedef enum logic [1:0] {
    ZD_KEEP  = 2'd0,
    ZD_EARLY = 2'd1,
    ZD_ALPHA = 2'd2,
    ZD_LATE  = 2'd3
  } zd_code_e;

endpackage

// File: rtl/zdu_depth_ram.sv
module zdu_depth_ram #(
  parameter int AWD     = 10,
  parameter int ZW      = 16,
  parameter int NRD     = 2,
  parameter logic [NRD-1:0] FWD_MASK = 2'b01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][AWD-1:0]  rd_addr,
  output logic [NRD-1:0][ZW-1:0]   rd_data,
  input  logic                     wr_en,
  input  logic [AWD-1:0]           wr_addr,
  input  logic [ZW-1:0]            wr_data,
  output logic                     busy
);
  localparam int DEPTH = 1 << AWD;
  localparam logic [AWD-1:0] LAST = AWD'(DEPTH - 1);

  logic [ZW-1:0]  mem [DEPTH];
  logic [AWD-1:0] sweep_idx;
  logic           sweep_on;

  logic           eff_we;
  logic [AWD-1:0] eff_addr;
  logic [ZW-1:0]  eff_data;

  assign eff_we   = sweep_on | wr_en;
  assign eff_addr = sweep_on ? sweep_idx : wr_addr;
  assign eff_data = sweep_on ? {ZW{1'b1}} : wr_data;
  assign busy     = sweep_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_on  <= 1'b1;
      sweep_idx <= '0;
    end else if (sweep_on) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (sweep_idx == LAST) sweep_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (eff_we) mem[eff_addr] <= eff_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    if (FWD_MASK[p]) begin : g_fwd
      assign rd_data[p] = (eff_we && (eff_addr == rd_addr[p])) ? eff_data : mem[rd_addr[p]];
    end else begin : g_plain
      assign rd_data[p] = mem[rd_addr[p]];
    end
  end

endmodule

// File: rtl/zdu_tex_delay.sv
module zdu_tex_delay #(
  parameter int W      = 38,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         v_q [STAGES];
  logic [W-1:0] d_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic         v_d;
    logic [W-1:0] d_d;
    if (s == 0) begin : g_head
      assign v_d = in_valid;
      assign d_d = in_data;
    end else begin : g_body
      assign v_d = v_q[s-1];
      assign d_d = d_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        d_q[s] <= '0;
      end else if (en) begin
        v_q[s] <= v_d;
        d_q[s] <= d_d;
      end
    end
  end

  assign out_valid = v_q[STAGES-1];
  assign out_data  = d_q[STAGES-1];

endmodule

// File: rtl/zdu_counters.sv
module zdu_counters #(
  parameter int N  = 3,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         inc,
  output logic [N-1:0][CW-1:0] cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/zdefer_unit.sv
module zdefer_unit
  import zdu_pkg::*;
#(
  parameter int XW      = 5,
  parameter int YW      = 5,
  parameter int ZW      = 16,
  parameter int AW      = 8,
  parameter int TEX_LAT = 4,
  parameter int CW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic [ZW-1:0] in_z,
  input  logic [AW-1:0] in_alpha,
  output logic          tex_req,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic [ZW-1:0] out_z,
  output logic [1:0]    out_code,
  output logic [CW-1:0] cnt_early,
  output logic [CW-1:0] cnt_alpha,
  output logic [CW-1:0] cnt_late,
  output logic          init_busy
);
  localparam int AWD = XW + YW;
  localparam int PKW = 1 + XW + YW + ZW + AW;
  localparam int RD_EARLY = 0;
  localparam int RD_LATE  = 1;

  // pipeline advance: frozen while a result waits
  logic adv, accept;
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv && !init_busy;
  assign accept   = in_valid && in_ready;

  // depth storage
  logic [1:0][AWD-1:0] rd_addr;
  logic [1:0][ZW-1:0]  rd_data;
  logic                ram_we;
  logic [AWD-1:0]      ram_waddr;
  logic [ZW-1:0]       ram_wdata;

  zdu_depth_ram #(
    .AWD(AWD), .ZW(ZW), .NRD(2), .FWD_MASK(2'b01)
  ) u_ram (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata),
    .busy(init_busy)
  );

  // early test on entry
  logic early_ok;
  assign rd_addr[RD_EARLY] = {in_y, in_x};
  assign early_ok          = in_z < rd_data[RD_EARLY];
  assign tex_req           = accept && early_ok;

  logic [PKW-1:0] issue_pkt;
  assign issue_pkt = {early_ok, in_x, in_y, in_z, (early_ok ? in_alpha : {AW{1'b0}})};

  // texture model: fixed delay, alpha returned at the tail
  logic           l_valid;
  logic [PKW-1:0] l_pkt;

  zdu_tex_delay #(.W(PKW), .STAGES(TEX_LAT)) u_tex (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_valid(accept), .in_data(issue_pkt),
    .out_valid(l_valid), .out_data(l_pkt)
  );

  logic          l_ok;
  logic [XW-1:0] l_x;
  logic [YW-1:0] l_y;
  logic [ZW-1:0] l_z;
  logic [AW-1:0] l_a;
  assign {l_ok, l_x, l_y, l_z, l_a} = l_pkt;

  // alpha test, then repeated depth test against the live buffer
  zd_code_e late_code;
  assign rd_addr[RD_LATE] = {l_y, l_x};

  always_comb begin
    if (!l_ok)                       late_code = ZD_EARLY;
    else if (l_a == '0)              late_code = ZD_ALPHA;
    else if (l_z < rd_data[RD_LATE]) late_code = ZD_KEEP;
    else                             late_code = ZD_LATE;
  end

  assign ram_we    = adv && l_valid && (late_code == ZD_KEEP);
  assign ram_waddr = {l_y, l_x};
  assign ram_wdata = l_z;

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
      out_code  <= ZD_KEEP;
    end else if (adv) begin
      out_valid <= l_valid;
      out_x     <= l_x;
      out_y     <= l_y;
      out_z     <= l_z;
      out_code  <= late_code;
    end
  end

  // reject tallies
  logic [2:0]         cnt_inc;
  logic [2:0][CW-1:0] cnt_all;
  assign cnt_inc[0] = adv && l_valid && (late_code == ZD_EARLY);
  assign cnt_inc[1] = adv && l_valid && (late_code == ZD_ALPHA);
  assign cnt_inc[2] = adv && l_valid && (late_code == ZD_LATE);

  zdu_counters #(.N(3), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_all)
  );

  assign cnt_early = cnt_all[0];
  assign cnt_alpha = cnt_all[1];
  assign cnt_late  = cnt_all[2];

endmodule

// File: rtl/zdefer_unit_chk.sv
module zdefer_unit_chk #(
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int ZW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          tex_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic [ZW-1:0] out_z,
  input logic [1:0]    out_code,
  input logic [CW-1:0] cnt_early,
  input logic [CW-1:0] cnt_alpha,
  input logic [CW-1:0] cnt_late,
  input logic          init_busy
);
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !in_ready); // R1

  AST_FETCH_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tex_req |-> (in_valid && in_ready)); // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_HELD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_z)
                                   && $stable(out_x) && $stable(out_y))); // R8

  AST_EARLY_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_early) |-> (out_valid && out_code == 2'd1
                             && cnt_early == $past(cnt_early) + 1'b1)); // R9

  AST_ALPHA_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_alpha) |-> (out_valid && out_code == 2'd2
                             && cnt_alpha == $past(cnt_alpha) + 1'b1)); // R9

  AST_LATE_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_late) |-> (out_valid && out_code == 2'd3
                            && cnt_late == $past(cnt_late) + 1'b1)); // R9

endmodule

bind zdefer_unit zdefer_unit_chk #(.XW(XW), .YW(YW), .ZW(ZW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .tex_req(tex_req), .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_code(out_code),
  .cnt_early(cnt_early), .cnt_alpha(cnt_alpha), .cnt_late(cnt_late),
  .init_busy(init_busy)
);

// File: tb/sim_zdefer_unit.sv
module sim_zdefer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 5, YW = 5, ZW = 16, AW = 8, LAT = 4, CW = 16;
  localparam int NPIX = 1 << (XW + YW);
  localparam int QN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          in_valid = 1'b0, in_ready, tex_req, out_valid, out_ready = 1'b0, init_busy;
  logic [XW-1:0] in_x = '0, out_x;
  logic [YW-1:0] in_y = '0, out_y;
  logic [ZW-1:0] in_z = '0, out_z;
  logic [AW-1:0] in_alpha = '0;
  logic [1:0]    out_code;
  logic [CW-1:0] cnt_early, cnt_alpha, cnt_late;

  zdefer_unit #(.XW(XW), .YW(YW), .ZW(ZW), .AW(AW), .TEX_LAT(LAT), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_alpha(in_alpha), .tex_req(tex_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_z(out_z), .out_code(out_code), .cnt_early(cnt_early), .cnt_alpha(cnt_alpha),
    .cnt_late(cnt_late), .init_busy(init_busy)
  );

  int checks = 0, fails = 0, cyc = 0, stalls = 0;
  bit done = 0;
  int mdl [NPIX];
  int qx[QN], qy[QN], qz[QN], qa[QN], qacc[QN], qst[QN];
  bit qe[QN];
  int qh = 0, qt = 0;
  bit acc_now = 0, atex = 0, hold_flag = 0;
  int ax, ay, az, aa;
  int s_code, s_x, s_y, s_z;
  int exp_e = 0, exp_a = 0, exp_l = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pix(input int x, input int y);
    return (y << XW) | x;
  endfunction

  task automatic retire();
    int e, p;
    string tag;
    if (qh == qt) begin
      chk(0, "R7", "result with nothing in flight", 1, 0);
      return;
    end
    p = pix(qx[qh], qy[qh]);
    if (!qe[qh])                begin e = 1; tag = "R2"; exp_e++; end
    else if (qa[qh] == 0)       begin e = 2; tag = "R4"; exp_a++; end
    else if (qz[qh] < mdl[p])   begin e = 0; tag = "R5"; mdl[p] = qz[qh]; end
    else                        begin e = 3; tag = "R6"; exp_l++; end
    chk(int'(out_code) == e, tag, "result code", int'(out_code), e);
    chk(int'(out_x) == qx[qh] && int'(out_y) == qy[qh] && int'(out_z) == qz[qh],
        "R7", "result order depth", int'(out_z), qz[qh]);
    chk(cyc - qacc[qh] == LAT + (stalls - qst[qh]), "R7", "latency",
        cyc - qacc[qh], LAT + (stalls - qst[qh]));
    qh = (qh + 1) % QN;
  endtask

  task automatic observe();
    bit e;
    cyc++;
    if (hold_flag) begin
      stalls++;
      chk(out_valid && int'(out_code) == s_code && int'(out_z) == s_z
          && int'(out_x) == s_x && int'(out_y) == s_y, "R8", "held result code",
          int'(out_code), s_code);
    end else if (out_valid) begin
      retire();
    end
    s_code = int'(out_code); s_x = int'(out_x); s_y = int'(out_y); s_z = int'(out_z);
    if (acc_now) begin
      e = az < mdl[pix(ax, ay)];
      chk(atex == e, "R3", "texel fetch on accept", int'(atex), int'(e));
      qx[qt] = ax; qy[qt] = ay; qz[qt] = az; qa[qt] = aa; qe[qt] = e;
      qacc[qt] = cyc; qst[qt] = stalls;
      qt = (qt + 1) % QN;
      acc_now = 0;
    end
  endtask

  task automatic drive(input bit v, input int x, input int y, input int z, input int a, input bit rdy);
    in_valid = v; in_x = XW'(x); in_y = YW'(y); in_z = ZW'(z); in_alpha = AW'(a);
    out_ready = rdy;
    #1;
    if (out_valid && !rdy) chk(!in_ready, "R8", "in_ready during stall", int'(in_ready), 0);
    hold_flag = out_valid && !rdy;
    if (v && in_ready) begin
      acc_now = 1; ax = x; ay = y; az = z; aa = a; atex = tex_req;
    end else if (tex_req) begin
      chk(0, "R3", "fetch without accept", 1, 0);
    end
    @(negedge clk);
    observe();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1'b1);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int n;
    for (int i = 0; i < NPIX; i++) mdl[i] = (1 << ZW) - 1;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(cnt_early == 0 && cnt_alpha == 0 && cnt_late == 0, "R1", "counters in reset",
        int'(cnt_early) + int'(cnt_alpha) + int'(cnt_late), 0);
    rst_n = 1'b1;
    #1;
    chk(!in_ready, "R1", "in_ready during clear", int'(in_ready), 0);
    n = 0;
    while (init_busy) begin
      if (in_ready) chk(0, "R1", "in_ready while clearing", 1, 0);
      n++;
      @(negedge clk);
    end
    chk(n == NPIX, "R1", "clear duration", n, NPIX);
    chk(in_ready, "R1", "ready after clear", int'(in_ready), 1);

    // kept, then equal depth rejected early
    drive(1, 3, 5, 100, 128, 1'b1); idle(LAT + 2);
    drive(1, 3, 5, 100, 9, 1'b1);
    chk(!atex, "R2", "no fetch for equal depth", int'(atex), 0);
    idle(LAT + 2);
    // alpha zero leaves buffer alone; nearer-than-100 still passes
    drive(1, 3, 5, 50, 0, 1'b1); idle(LAT + 2);
    drive(1, 3, 5, 60, 1, 1'b1); idle(LAT + 2);
    // in-flight hazard: near then far back to back, and the reverse
    drive(1, 7, 7, 20, 200, 1'b1); drive(1, 7, 7, 30, 200, 1'b1); idle(LAT + 2);
    drive(1, 9, 9, 30, 200, 1'b1); drive(1, 9, 9, 20, 200, 1'b1); idle(LAT + 2);
    chk(cnt_late == 1, "R6", "one late reject so far", int'(cnt_late), 1);
    // write and early read of one pixel in the same cycle
    drive(1, 1, 2, 500, 77, 1'b1); idle(LAT - 1);
    drive(1, 1, 2, 500, 77, 1'b1);
    chk(!atex, "R10", "forwarded write seen by early test", int'(atex), 0);
    idle(LAT + 2);

    // random traffic on a crowded corner with back-pressure
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 5) != 0, $urandom % 4, $urandom % 4, $urandom % 64,
            (($urandom % 4) == 0) ? 0 : 1 + ($urandom % 255), ($urandom % 10) < 7);
    end
    idle(LAT + 4);

    chk(qh == qt, "R7", "all results returned", (qt - qh + QN) % QN, 0);
    chk(int'(cnt_early) == exp_e, "R9", "early count", int'(cnt_early), exp_e);
    chk(int'(cnt_alpha) == exp_a, "R9", "alpha count", int'(cnt_alpha), exp_a);
    chk(int'(cnt_late) == exp_l, "R9", "late count", int'(cnt_late), exp_l);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule